// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to sixteen interrupt request lines, turns each into a pending request according to its own trigger mode, and presents the most urgent request to a single processor on one interrupt line. Each line can trigger on a level or on an edge, and either polarity can be chosen. Each line has its own 4-bit priority, 8-bit vector, mask bit and routing bit. The processor reads an acknowledge register to learn the vector and claim the interrupt. It writes an end-of-interrupt register when its handler is done.

Claimed interrupts are held in an in-service set, so handlers can nest. A request is delivered only if its priority is strictly above both the task priority and the most urgent interrupt already in service. If no request qualifies when the acknowledge register is read, the read returns a programmable spurious vector. Software changes a line's setup by masking it first and then polling its activity bit until the bit reads zero. A self-clearing bit in the configuration register restarts the whole block.

Top module: `vpic_top`

## Requirements
- R11: Register access uses word addresses. The addresses are: 0x00 configuration (bit 0 starts a reset), 0x01 feature, 0x02 spurious vector, 0x03 task priority, 0x04 acknowledge, 0x05 end-of-interrupt. Line i has its control word at 0x10+2i and its routing word at 0x11+2i. Control word fields: bit 31 mask (1 = disabled), bit 30 activity (read-only), bit 17 sense (1 = level, 0 = edge), bit 16 polarity (1 = high or rising, 0 = low or falling), bits 11:8 priority, bits 7:0 vector. The routing word keeps only bit 0. Any other address reads 0, and a write to it has no effect.
- R1: After reset, every control word reads 0x8000_0000 (masked), every routing word reads 0, the task priority reads 15, the spurious vector reads 0xFF, the configuration register reads 0, and irq_o is low.
- R2: The feature register reads version 2 in bits 19:16, the last processor index 0 in bits 15:8, and NUM_SRC-1 in bits 7:0.
- R3: A level-sense line is pending in every cycle that its input sits at the active level, and it stops being pending as soon as the input leaves that level.
- R4: An edge-sense line latches pending on a transition into its active level. The latch holds after the input returns, and it is cleared when that line is acknowledged, when the line is masked, or when the line is set to level sense.
- R5: A line is delivered only when it is unmasked, pending, routed (routing bit 0 set) and has a priority above 0 and above the task priority. A task priority of 15 holds off every line.
- R6: Of all deliverable lines, the one with the highest priority wins. When priorities are equal, the lower-numbered line wins. irq_o is high exactly when some line can be delivered.
- R7: A read of the acknowledge register returns the winning vector in bits 7:0. The winning line enters in-service, and an edge line's latch is cleared. If no line can be delivered, the read returns the spurious vector and changes nothing.
- R8: A line is also delivered only if its priority is strictly above the highest in-service priority. Any write to end-of-interrupt retires the in-service line with the highest priority, choosing the lower number on a tie. A read of end-of-interrupt returns 0 and has no effect.
- R9: The activity bit reads 1 while the line is pending (unmasked) or in service. Once a line is masked, its activity bit reads 0 as soon as the line leaves service.
- R10: Writing 1 to configuration bit 0 makes that bit read 1 for RST_CYCLES cycles. During that time irq_o is low, bus writes are ignored and every register is returned to its reset value. The bit then clears by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt request lines, synchronous to clk_i |
| bus_req_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the access |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The checks assume that src_i is already synchronous to clk_i and that each register access lasts exactly one cycle, with no second access stacked on it. The stimulus changes the request lines and the bus signals only on the falling clock edge and issues at most one access per cycle. The checks also assume that software never relies on an end-of-interrupt write to an empty in-service set. The random phase mixes such writes in freely, and the bench model treats them as having no effect.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int unsigned PRIO_W = 4;
  localparam int unsigned VEC_W  = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 6;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [VEC_W-1:0]  vec_t;

  typedef struct packed {
    logic  mask;
    logic  sense;
    logic  pol;
    prio_t prio;
    vec_t  vec;
  } src_cfg_t;

  localparam src_cfg_t CFG_RST = '{mask: 1'b1, sense: 1'b0, pol: 1'b0, prio: '0, vec: '0};

  localparam logic [ADDR_W-1:0] A_CFG  = 6'h00;
  localparam logic [ADDR_W-1:0] A_FEAT = 6'h01;
  localparam logic [ADDR_W-1:0] A_SPUR = 6'h02;
  localparam logic [ADDR_W-1:0] A_TPR  = 6'h03;
  localparam logic [ADDR_W-1:0] A_ACK  = 6'h04;
  localparam logic [ADDR_W-1:0] A_EOI  = 6'h05;
  localparam logic [ADDR_W-1:0] A_SRC  = 6'h10;

  localparam int unsigned B_MASK  = 31;
  localparam int unsigned B_ACT   = 30;
  localparam int unsigned B_SENSE = 17;
  localparam int unsigned B_POL   = 16;
  localparam int unsigned B_PRIO  = 8;

  localparam logic [3:0] VERSION = 4'd2;
endpackage

// File: rtl/vpic_src.sv
module vpic_src
  import vpic_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     src_i,
  input  logic     cfg_we_i,
  input  src_cfg_t cfg_i,
  input  logic     dst_we_i,
  input  logic     dst_i,
  input  logic     ack_i,
  output src_cfg_t cfg_o,
  output logic     dst_o,
  output logic     pend_o
);
  logic prev_q, edge_q, at_lvl, edge_hit;

  assign at_lvl   = (src_i == cfg_o.pol);
  assign edge_hit = at_lvl & (src_i != prev_q);
  // R3/R4: level follows the pin, edge uses the latch
  assign pend_o   = ~cfg_o.mask & (cfg_o.sense ? at_lvl : edge_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o  <= CFG_RST;
      dst_o  <= 1'b0;
      prev_q <= 1'b0;
      edge_q <= 1'b0;
    end else if (clr_i) begin
      cfg_o  <= CFG_RST;
      dst_o  <= 1'b0;
      prev_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      prev_q <= src_i;
      // latch dropped while masked so the activity bit can settle (R9)
      edge_q <= (cfg_o.mask | cfg_o.sense) ? 1'b0 : ((edge_q & ~ack_i) | edge_hit);
      if (cfg_we_i) cfg_o <= cfg_i;
      if (dst_we_i) dst_o <= dst_i;
    end
  end
endmodule

// File: rtl/vpic_arb.sv
module vpic_arb
  import vpic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]  pend_i,
  input  logic [NUM_SRC-1:0]  dst_i,
  input  prio_t [NUM_SRC-1:0] prio_i,
  output logic                win_vld_o,
  output logic [IDX_W-1:0]    win_idx_o,
  output prio_t               win_prio_o
);
  // R6: strict compare keeps the lower index on ties; priority 0 never wins (R5)
  always_comb begin
    logic             vld;
    logic [IDX_W-1:0] idx;
    prio_t            best;
    vld  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_i[i] && dst_i[i] && (prio_i[i] > best)) begin
        vld  = 1'b1;
        idx  = IDX_W'(i);
        best = prio_i[i];
      end
    end
    win_vld_o  = vld;
    win_idx_o  = idx;
    win_prio_o = best;
  end
endmodule

// File: rtl/vpic_isr.sv
module vpic_isr
  import vpic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                set_i,
  input  logic [IDX_W-1:0]    set_idx_i,
  input  logic                eoi_i,
  input  prio_t [NUM_SRC-1:0] prio_i,
  output logic [NUM_SRC-1:0]  isr_o,
  output prio_t               top_prio_o
);
  logic             any;
  logic [IDX_W-1:0] top_idx;

  // R8: most urgent in-service entry, lower index on ties
  always_comb begin
    any        = 1'b0;
    top_idx    = '0;
    top_prio_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (isr_o[i] && (!any || (prio_i[i] > top_prio_o))) begin
        any        = 1'b1;
        top_idx    = IDX_W'(i);
        top_prio_o = prio_i[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_o <= '0;
    end else if (clr_i) begin
      isr_o <= '0;
    end else begin
      if (eoi_i && any) isr_o[top_idx] <= 1'b0;
      if (set_i)        isr_o[set_idx_i] <= 1'b1;
    end
  end
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 16,
  parameter int unsigned RST_CYCLES = 4,
  parameter logic [7:0]  SPUR_RST   = 8'hFF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_req_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               irq_o
);
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [ADDR_W-1:0] SRC_END = A_SRC + ADDR_W'(2 * NUM_SRC);

  logic                rd, wr, busy, src_hit, deliver, ack_take, eoi;
  logic [CNT_W-1:0]    rcnt_q;
  prio_t               tpr_q, isr_top, win_prio;
  vec_t                spur_q;
  logic [ADDR_W-1:0]   src_off;
  logic [IDX_W-1:0]    sel_idx, win_idx;
  logic                win_vld;
  src_cfg_t            cfg_wr;
  src_cfg_t            cfg [NUM_SRC];
  logic [DATA_W-1:0]   vp_rd [NUM_SRC];
  logic [NUM_SRC-1:0]  dst, pend, isr_vec;
  prio_t [NUM_SRC-1:0] prio_all;

  assign rd      = bus_req_i & ~bus_we_i;
  assign wr      = bus_req_i & bus_we_i;
  assign busy    = (rcnt_q != '0);
  assign src_hit = (bus_addr_i >= A_SRC) && (bus_addr_i < SRC_END);
  assign src_off = bus_addr_i - A_SRC;
  assign sel_idx = src_off[IDX_W:1];

  always_comb begin
    cfg_wr.mask  = bus_wdata_i[B_MASK];
    cfg_wr.sense = bus_wdata_i[B_SENSE];
    cfg_wr.pol   = bus_wdata_i[B_POL];
    cfg_wr.prio  = bus_wdata_i[B_PRIO +: PRIO_W];
    cfg_wr.vec   = bus_wdata_i[VEC_W-1:0];
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic sel;
    assign sel = wr & ~busy & src_hit & (sel_idx == IDX_W'(g));
    vpic_src u_src (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (busy),
      .src_i    (src_i[g]),
      .cfg_we_i (sel & ~bus_addr_i[0]),
      .cfg_i    (cfg_wr),
      .dst_we_i (sel & bus_addr_i[0]),
      .dst_i    (bus_wdata_i[0]),
      .ack_i    (ack_take && (win_idx == IDX_W'(g))),
      .cfg_o    (cfg[g]),
      .dst_o    (dst[g]),
      .pend_o   (pend[g])
    );
    assign prio_all[g] = cfg[g].prio;
    assign vp_rd[g] = {cfg[g].mask, pend[g] | isr_vec[g], 12'b0, cfg[g].sense, cfg[g].pol,
                       4'b0, cfg[g].prio, cfg[g].vec};
  end

  vpic_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .pend_i     (pend),
    .dst_i      (dst),
    .prio_i     (prio_all),
    .win_vld_o  (win_vld),
    .win_idx_o  (win_idx),
    .win_prio_o (win_prio)
  );

  // R5/R8: must beat task priority and everything in service
  assign deliver  = ~busy & win_vld & (win_prio > tpr_q) & (win_prio > isr_top);
  assign irq_o    = deliver;
  assign ack_take = rd & (bus_addr_i == A_ACK) & deliver;
  assign eoi      = wr & (bus_addr_i == A_EOI) & ~busy;

  vpic_isr #(.NUM_SRC(NUM_SRC)) u_isr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (busy),
    .set_i      (ack_take),
    .set_idx_i  (win_idx),
    .eoi_i      (eoi),
    .prio_i     (prio_all),
    .isr_o      (isr_vec),
    .top_prio_o (isr_top)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rcnt_q <= '0;
      tpr_q  <= '1;
      spur_q <= SPUR_RST;
    end else if (busy) begin
      rcnt_q <= rcnt_q - 1'b1;
      tpr_q  <= '1;
      spur_q <= SPUR_RST;
    end else begin
      if (wr && (bus_addr_i == A_CFG) && bus_wdata_i[0]) rcnt_q <= CNT_W'(RST_CYCLES);
      if (wr && (bus_addr_i == A_TPR))  tpr_q  <= bus_wdata_i[PRIO_W-1:0];
      if (wr && (bus_addr_i == A_SPUR)) spur_q <= bus_wdata_i[VEC_W-1:0];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (src_hit) begin
      if (bus_addr_i[0]) bus_rdata_o = {31'b0, dst[sel_idx]};
      else               bus_rdata_o = vp_rd[sel_idx];
    end else begin
      case (bus_addr_i)
        A_CFG:   bus_rdata_o = {31'b0, busy};
        A_FEAT:  bus_rdata_o = {12'b0, VERSION, 8'd0, 8'(NUM_SRC - 1)};
        A_SPUR:  bus_rdata_o = {24'b0, spur_q};
        A_TPR:   bus_rdata_o = {28'b0, tpr_q};
        A_ACK:   bus_rdata_o = {24'b0, deliver ? cfg[win_idx].vec : spur_q};
        default: bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/vpic_sva.sv
module vpic_sva
  import vpic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_req_i,
  input logic               bus_we_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [DATA_W-1:0]  bus_wdata_i,
  input logic [DATA_W-1:0]  bus_rdata_o,
  input logic               irq_o,
  input logic               busy_i,
  input prio_t              tpr_i,
  input vec_t               spur_i,
  input logic [NUM_SRC-1:0] isr_i
);
  logic ack_rd, eoi_wr, rst_wr;
  assign ack_rd = bus_req_i & ~bus_we_i & (bus_addr_i == A_ACK);
  assign eoi_wr = bus_req_i & bus_we_i & (bus_addr_i == A_EOI);
  assign rst_wr = bus_req_i & bus_we_i & (bus_addr_i == A_CFG) & bus_wdata_i[0];

  p_tpr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tpr_i == 4'hF) |-> !irq_o);

  p_spur_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd && !irq_o) |-> (bus_rdata_o == {24'b0, spur_i}));

  p_ack_push_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd && irq_o) |=> ($countones(isr_i) == $countones($past(isr_i)) + 1));

  p_eoi_pop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_wr && !busy_i && (isr_i != '0)) |=> ($countones(isr_i) + 1 == $countones($past(isr_i))));

  p_quiet_rst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !irq_o);

  p_rst_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_wr && !busy_i) |=> busy_i);
endmodule

bind vpic_top vpic_sva #(.NUM_SRC(NUM_SRC)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o),
  .busy_i      (busy),
  .tpr_i       (tpr_q),
  .spur_i      (spur_q),
  .isr_i       (isr_vec)
);

// File: tb/vpic_top_tb.sv
module vpic_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int RSTC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [5:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;
  int            checks = 0, fails = 0;

  vpic_top #(.NUM_SRC(N), .RST_CYCLES(RSTC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model ----------------
  bit         m_mask[N], m_sense[N], m_pol[N], m_dst[N], m_pend[N], m_prev[N], m_isr[N];
  logic [3:0] m_prio[N];
  logic [7:0] m_vec[N];
  logic [3:0] m_tpr;
  logic [7:0] m_spur;
  int         m_cnt;

  function automatic void m_defaults();
    for (int i = 0; i < N; i++) begin
      m_mask[i] = 1; m_sense[i] = 0; m_pol[i] = 0; m_dst[i] = 0;
      m_pend[i] = 0; m_prev[i] = 0; m_isr[i] = 0; m_prio[i] = 0; m_vec[i] = 0;
    end
    m_tpr = 4'hF; m_spur = 8'hFF;
  endfunction

  function automatic bit m_pf(int i);
    if (m_mask[i]) return 0;
    return m_sense[i] ? (src[i] == m_pol[i]) : m_pend[i];
  endfunction

  function automatic int m_win();
    int w = -1;
    logic [3:0] bp = 0;
    for (int i = 0; i < N; i++)
      if (m_pf(i) && m_dst[i] && m_prio[i] > bp) begin w = i; bp = m_prio[i]; end
    return w;
  endfunction

  function automatic int m_itop();
    int t = -1;
    for (int i = 0; i < N; i++)
      if (m_isr[i] && (t < 0 || m_prio[i] > m_prio[t])) t = i;
    return t;
  endfunction

  function automatic int m_dlv();
    int w = m_win();
    int t = m_itop();
    logic [3:0] tp = (t < 0) ? 4'd0 : m_prio[t];
    if (m_cnt != 0 || w < 0) return -1;
    if (m_prio[w] > m_tpr && m_prio[w] > tp) return w;
    return -1;
  endfunction

  function automatic logic [31:0] m_rd(logic [5:0] a);
    int d;
    if (a >= 6'h10 && a < 6'(16 + 2*N)) begin
      int i = (int'(a) - 16) / 2;
      if (a[0]) return {31'b0, m_dst[i]};
      return {m_mask[i], m_pf(i) | m_isr[i], 12'b0, m_sense[i], m_pol[i], 4'b0, m_prio[i], m_vec[i]};
    end
    case (a)
      6'h00: return {31'b0, m_cnt != 0};
      6'h01: return 32'h0002_0000 | 32'(N - 1);
      6'h02: return {24'b0, m_spur};
      6'h03: return {28'b0, m_tpr};
      6'h04: begin d = m_dlv(); return {24'b0, (d >= 0) ? m_vec[d] : m_spur}; end
      default: return 32'h0;
    endcase
  endfunction

  function automatic void m_step();
    int d, ack, t;
    bit rd_, wr_, eh;
    if (m_cnt != 0) begin
      m_defaults();
      m_cnt--;
      return;
    end
    d = m_dlv();
    rd_ = req && !we;
    wr_ = req && we;
    ack = (rd_ && addr == 6'h04) ? d : -1;
    if (wr_ && addr == 6'h05) begin
      t = m_itop();
      if (t >= 0) m_isr[t] = 0;
    end
    if (ack >= 0) m_isr[ack] = 1;
    for (int i = 0; i < N; i++) begin
      eh = (src[i] == m_pol[i]) && (src[i] != m_prev[i]);
      if (m_mask[i] || m_sense[i]) m_pend[i] = 0;
      else m_pend[i] = (m_pend[i] && ack != i) || eh;
      m_prev[i] = src[i];
    end
    if (wr_) begin
      if (addr >= 6'h10 && addr < 6'(16 + 2*N)) begin
        int i = (int'(addr) - 16) / 2;
        if (addr[0]) m_dst[i] = wdata[0];
        else begin
          m_mask[i] = wdata[31]; m_sense[i] = wdata[17]; m_pol[i] = wdata[16];
          m_prio[i] = wdata[11:8]; m_vec[i] = wdata[7:0];
        end
      end
      case (addr)
        6'h00: if (wdata[0]) m_cnt = RSTC;
        6'h02: m_spur = wdata[7:0];
        6'h03: m_tpr = wdata[3:0];
        default: ;
      endcase
    end
  endfunction

  // ---------------- check helpers ----------------
  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit r, bit w, logic [5:0] a, logic [31:0] d, logic [N-1:0] s, string tag);
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d; src = s;
    #1;
    chk(tag, "irq_o", {31'b0, irq}, {31'b0, m_dlv() >= 0});
    if (r && !w) chk(tag, $sformatf("rdata@%h", a), rdata, m_rd(a));
    m_step();
  endtask

  task automatic wr_r(logic [5:0] a, logic [31:0] d, string tag); cyc(1, 1, a, d, src, tag); endtask
  task automatic rd_r(logic [5:0] a, string tag); cyc(1, 0, a, 32'h0, src, tag); endtask
  task automatic drive(logic [N-1:0] s, string tag); cyc(0, 0, 6'h0, 32'h0, s, tag); endtask

  function automatic logic [31:0] vp(bit mask, bit sense, bit pol, logic [3:0] pr, logic [7:0] v);
    return {mask, 13'b0, sense, pol, 4'b0, pr, v};
  endfunction

  task automatic setup(int i, logic [3:0] pr, logic [7:0] v, bit sense, bit pol, string tag);
    wr_r(6'(16 + 2*i), vp(0, sense, pol, pr, v), tag);
    wr_r(6'(17 + 2*i), 32'h1, tag);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd20240611));
    m_defaults();
    m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R11 layout
    rd_r(6'h10, "R1"); chk("R1", "vp0 reset", rdata, 32'h8000_0000);
    rd_r(6'h2E, "R1"); rd_r(6'h11, "R1");
    rd_r(6'h03, "R1"); rd_r(6'h02, "R1"); rd_r(6'h00, "R1");
    rd_r(6'h09, "R11"); rd_r(6'h30, "R11");
    // R2 feature
    rd_r(6'h01, "R2"); chk("R2", "feature", rdata, 32'h0002_000F);

    wr_r(6'h03, 32'h0, "R5");
    // R3 level, active high
    setup(3, 4'd5, 8'h33, 1, 1, "R3");
    drive(16'h0000, "R3");
    drive(16'h0008, "R3");
    drive(16'h0000, "R3");
    drive(16'h0008, "R3");
    rd_r(6'h04, "R7"); chk("R7", "ack vec", rdata, 32'h33);
    rd_r(6'h16, "R9");
    wr_r(6'h05, 32'h0, "R8");
    drive(16'h0000, "R3");
    // R3 level, active low
    setup(4, 4'd5, 8'h44, 1, 0, "R3");
    drive(16'h0000, "R3");
    drive(16'h0010, "R3");
    wr_r(6'h18, 32'h8000_0000, "R9");
    drive(16'h0000, "R3");

    // R4 rising edge
    setup(6, 4'd7, 8'h66, 0, 1, "R4");
    drive(16'h0040, "R4");
    drive(16'h0000, "R4");
    drive(16'h0000, "R4");
    rd_r(6'h04, "R7"); chk("R4", "edge ack", rdata, 32'h66);
    drive(16'h0000, "R4");
    wr_r(6'h05, 32'h0, "R8");
    // R4 falling edge
    drive(16'h0080, "R4");
    setup(7, 4'd7, 8'h77, 0, 0, "R4");
    drive(16'h0000, "R4");
    drive(16'h0000, "R4");
    rd_r(6'h04, "R4");
    wr_r(6'h05, 32'h0, "R8");

    // R6 tie on priority
    setup(1, 4'd6, 8'h11, 0, 1, "R6");
    setup(2, 4'd6, 8'h22, 0, 1, "R6");
    drive(16'h0006, "R6");
    drive(16'h0000, "R6");
    rd_r(6'h04, "R6"); chk("R6", "tie winner", rdata, 32'h11);
    rd_r(6'h04, "R8"); chk("R8", "equal prio held", rdata, 32'hFF);
    wr_r(6'h05, 32'h0, "R8");
    rd_r(6'h04, "R6"); chk("R6", "second", rdata, 32'h22);
    wr_r(6'h05, 32'h0, "R8");

    // R8 nesting
    setup(9, 4'd3, 8'h99, 0, 1, "R8");
    setup(10, 4'd9, 8'hAA, 0, 1, "R8");
    drive(16'h0200, "R8"); drive(16'h0000, "R8");
    rd_r(6'h04, "R8"); chk("R8", "outer", rdata, 32'h99);
    drive(16'h0400, "R8"); drive(16'h0000, "R8");
    rd_r(6'h04, "R8"); chk("R8", "inner", rdata, 32'hAA);
    rd_r(6'h05, "R8"); chk("R8", "eoi read", rdata, 32'h0);
    rd_r(6'h24, "R9"); rd_r(6'h22, "R9");
    wr_r(6'h05, 32'h0, "R8");
    rd_r(6'h24, "R9"); rd_r(6'h22, "R9");
    wr_r(6'h05, 32'h0, "R8");
    rd_r(6'h22, "R9");

    // R5 routing and priority 0
    wr_r(6'h23, 32'h0, "R5");
    drive(16'h0200, "R5"); drive(16'h0000, "R5");
    rd_r(6'h04, "R5");
    wr_r(6'h23, 32'h1, "R5");
    drive(16'h0000, "R5");
    setup(12, 4'd0, 8'hCC, 1, 1, "R5");
    drive(16'h1000, "R5");
    drive(16'h0000, "R5");
    rd_r(6'h04, "R5");
    wr_r(6'h05, 32'h0, "R8");
    // R5/R7 task priority 15
    drive(16'h0200, "R5"); drive(16'h0000, "R5");
    wr_r(6'h03, 32'hF, "R5");
    rd_r(6'h04, "R7"); chk("R7", "spurious", rdata, 32'hFF);
    wr_r(6'h02, 32'h5A, "R7");
    rd_r(6'h04, "R7"); chk("R7", "spurious prog", rdata, 32'h5A);
    wr_r(6'h03, 32'h0, "R5");
    rd_r(6'h04, "R7"); chk("R7", "after tpr", rdata, 32'h99);

    // R9 mask-then-wait handshake
    wr_r(6'h22, vp(1, 0, 1, 4'd3, 8'h99), "R9");
    rd_r(6'h22, "R9"); chk("R9", "act in service", rdata[31:30], 2'b11);
    wr_r(6'h05, 32'h0, "R8");
    rd_r(6'h22, "R9"); chk("R9", "act cleared", rdata[31:30], 2'b10);
    wr_r(6'h22, vp(1, 1, 0, 4'd8, 8'h9B), "R9");
    rd_r(6'h22, "R9");

    // R10 self-clearing reset
    drive(16'h0008, "R10");
    wr_r(6'h00, 32'h1, "R10");
    for (int k = 0; k < RSTC + 2; k++) rd_r(6'h00, "R10");
    rd_r(6'h16, "R10"); chk("R10", "masked after", rdata[31], 1'b1);
    rd_r(6'h03, "R10");

    // random phase
    wr_r(6'h03, 32'h0, "R5");
    for (int k = 0; k < 6000; k++) begin
      int op = $urandom_range(0, 99);
      logic [N-1:0] s = src ^ (N'($urandom) & N'($urandom) & N'($urandom));
      logic [31:0] d = $urandom;
      logic [5:0] sa = 6'(16 + 2*$urandom_range(0, N-1));
      if (op < 35) drive(s, "R3");
      else if (op < 58) rd_r(6'h04, "R7");
      else if (op < 68) wr_r(6'h05, d, "R8");
      else if (op < 82) begin d[31] = ($urandom_range(0, 3) == 0); wr_r(sa, d, "R9"); end
      else if (op < 87) wr_r(sa | 6'h1, {31'b0, ($urandom_range(0, 4) != 0)}, "R5");
      else if (op < 91) wr_r(6'h03, 32'($urandom_range(0, 6)), "R5");
      else if (op < 99) rd_r(6'($urandom_range(0, 63)), "R6");
      else if ($urandom_range(0, 7) == 0) wr_r(6'h00, 32'h1, "R10");
      else drive(s, "R4");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule